// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block collects 96 interrupt requests into one interrupt line for a processor. Two 32-bit main cause banks take requests from on-chip units: the lower bank holds sources 0 to 31 and the upper bank holds sources 32 to 63. A third 32-bit bank captures general-purpose port pins as sources 64 to 95. That port bank has its own cause and mask layer. Its masked bits are reduced in groups of eight into four summary bits that sit inside the upper main bank.

Each bank has a mask. A priority resolver reports one interrupt number from the pending sources. It checks the lower bank first, then the upper bank. When an upper-bank summary bit wins, it descends into the port bank. Software reaches all state through a small register port with an 8-word map. It reads the cause and mask banks and the resolved number, writes the masks and the capture-mode control, and clears port cause bits by writing zeros.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Interrupt numbers map as follows: lower-bank bit i is number i, upper-bank bit i is number 32+i, and port bit i is number 64+i. A resolved number is always below 96 or equal to the no-interrupt code.
- R2: The resolver reports the lowest-numbered eligible source in the lower bank. Only when none is found does it look at the upper bank, and it takes the lowest eligible bit there.
- R3: Only lower-bank bits in 0x3DFFFFFE take part. Requests on bits 0, 25, 30 and 31 never produce a number.
- R4: Only upper-bank bits in 0x0F000DB7 take part. Upper-bank bits 24 to 27 ignore the unit inputs. Instead, bit 24+g is set when any port cause bit in 8g to 8g+7 is set while its port mask bit is one.
- R5: When the winning upper-bank bit is a summary bit, the reported number is 64 plus the lowest bit index of (port cause AND port mask).
- R6: A write to the port cause word (address 2) clears each bit written as 0 and leaves each bit written as 1 unchanged. Port cause bits are never cleared in any other way.
- R7: Bit 10 of the control word (address 6) selects the capture mode. When it is 1, a port cause bit is set in every cycle its registered pin is high, and that set overrides a clear in the same cycle. When it is 0, only a rising pin sets the bit, and the bit then holds until it is cleared. In both modes a same-cycle capture wins over a clear.
- R8: After synchronous reset, every mask, the port cause word and the control word are zero, the interrupt line is low, and the resolved-number word reads 0xFFFFFFFE.
- R9: The interrupt line is registered and is high exactly when the registered resolved number is not the no-interrupt code 0xFFFFFFFE.
- R10: The register map is 0 lower cause, 1 upper cause (with the summary bits), 2 port cause, 3 lower mask, 4 upper mask, 5 port mask, 6 control, 7 resolved number. Read data is registered and shows the addressed word one cycle after the address is presented. Writes to addresses 0, 1 and 7 have no effect.
- R11: A request on a main-bank input reaches the interrupt line two clock edges later. A port pin reaches it three edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lo | input | 32 | Unit requests for sources 0-31 |
| src_hi | input | 32 | Unit requests for sources 32-63 (bits 24-27 unused) |
| port_pin | input | 32 | Port pins, sources 64-95 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Registered processor interrupt line |

## Verification
In the same cycle, a software write-zero clear of a port cause bit can coincide with a new capture of that same bit. The capture can come from a rising edge in edge mode or from a held pin in level mode. The bench provokes this in two ways. It holds a clear write on the port cause word across the cycle in which a pin's rising edge is captured. It also issues clears while a pin is held high in level mode. The bench's behavioural model gives the capture priority, and it compares the read data and the interrupt line with the model on every clock. Directed reads of the port cause word then confirm that the bit survived.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    RA_LO_CAUSE   = 3'd0,
    RA_HI_CAUSE   = 3'd1,
    RA_PORT_CAUSE = 3'd2,
    RA_LO_MASK    = 3'd3,
    RA_HI_MASK    = 3'd4,
    RA_PORT_MASK  = 3'd5,
    RA_CTRL       = 3'd6,
    RA_CURRENT    = 3'd7
  } reg_addr_e;

  localparam int unsigned MASK_BANKS = 3;
endpackage

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_port_bank.sv
module irqc_port_bank #(
  parameter int W       = 32,
  parameter int GROUP_W = 8,
  parameter int GROUPS  = W / GROUP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      pin,
  input  logic              level_mode,
  input  logic              clr_en,
  input  logic [W-1:0]      clr_word,
  input  logic [W-1:0]      mask,
  output logic [W-1:0]      cause,
  output logic [GROUPS-1:0] summary
);
  logic [W-1:0] pin_q, pin_prev, cause_q;
  logic [W-1:0] capture, kept, masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= '0;
      pin_prev <= '0;
      cause_q  <= '0;
    end else begin
      pin_q    <= pin;
      pin_prev <= pin_q;
      cause_q  <= kept | capture;
    end
  end

  always_comb begin
    capture = level_mode ? pin_q : (pin_q & ~pin_prev);
    kept    = clr_en ? (cause_q & clr_word) : cause_q;
    masked  = cause_q & mask;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_sum
    assign summary[g] = |masked[g*GROUP_W +: GROUP_W];
  end

  assign cause = cause_q;
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int          W       = 32,
  parameter int          SUM_LSB = 24,
  parameter int          GROUPS  = 4,
  parameter int          CODE_W  = 32,
  parameter logic [CODE_W-1:0] NONE = '1 - 1
) (
  input  logic [W-1:0]      lo_pend,
  input  logic [W-1:0]      hi_pend,
  input  logic [W-1:0]      port_pend,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  localparam int IDX_W = $clog2(W);

  logic             lo_found, hi_found, port_found;
  logic [IDX_W-1:0] lo_idx, hi_idx, port_idx;

  irqc_first_set #(.W(W)) u_lo   (.vec(lo_pend),   .found(lo_found),   .idx(lo_idx));
  irqc_first_set #(.W(W)) u_hi   (.vec(hi_pend),   .found(hi_found),   .idx(hi_idx));
  irqc_first_set #(.W(W)) u_port (.vec(port_pend), .found(port_found), .idx(port_idx));

  always_comb begin
    valid = 1'b0;
    code  = NONE;
    if (lo_found) begin
      valid = 1'b1;
      code  = CODE_W'(int'(lo_idx));
    end else if (hi_found) begin
      if (int'(hi_idx) >= SUM_LSB && int'(hi_idx) < SUM_LSB + GROUPS) begin
        if (port_found) begin
          valid = 1'b1;
          code  = CODE_W'(2 * W + int'(port_idx));
        end
      end else begin
        valid = 1'b1;
        code  = CODE_W'(W + int'(hi_idx));
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int              W         = 32,
  parameter int              GROUP_W   = 8,
  parameter int              SUM_LSB   = 24,
  parameter int              LEVEL_BIT = 10,
  parameter logic [W-1:0]    LO_VALID  = 32'h3DFF_FFFE,
  parameter logic [W-1:0]    HI_VALID  = 32'h0F00_0DB7,
  parameter logic [W-1:0]    NONE_CODE = 32'hFFFF_FFFE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_lo,
  input  logic [W-1:0] src_hi,
  input  logic [W-1:0] port_pin,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         cpu_irq
);
  localparam int           GROUPS    = W / GROUP_W;
  localparam logic [W-1:0] SUM_FIELD = W'({GROUPS{1'b1}}) << SUM_LSB;

  logic [W-1:0]      lo_cause_q, hi_src_q, hi_cause;
  logic [W-1:0]      mask_q [MASK_BANKS];
  logic [W-1:0]      port_cause;
  logic [GROUPS-1:0] port_summary;
  logic              level_q;
  logic [W-1:0]      lo_pend, hi_pend, port_pend;
  logic              res_valid;
  logic [W-1:0]      res_code;
  logic [W-1:0]      cur_code_q;
  logic              irq_q;
  logic [W-1:0]      rdata_q, rdata_d;
  reg_addr_e         addr_e;

  assign addr_e = reg_addr_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cause_q <= '0;
      hi_src_q   <= '0;
      level_q    <= 1'b0;
    end else begin
      lo_cause_q <= src_lo;
      hi_src_q   <= src_hi;
      if (reg_we && addr_e == RA_CTRL) level_q <= reg_wdata[LEVEL_BIT];
    end
  end

  for (genvar b = 0; b < MASK_BANKS; b++) begin : g_mask
    localparam logic [2:0] MADDR = 3'(int'(RA_LO_MASK) + b);
    always_ff @(posedge clk) begin
      if (rst)                             mask_q[b] <= '0;
      else if (reg_we && reg_addr == MADDR) mask_q[b] <= reg_wdata;
    end
  end

  irqc_port_bank #(.W(W), .GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_port (
    .clk        (clk),
    .rst        (rst),
    .pin        (port_pin),
    .level_mode (level_q),
    .clr_en     (reg_we && addr_e == RA_PORT_CAUSE),
    .clr_word   (reg_wdata),
    .mask       (mask_q[2]),
    .cause      (port_cause),
    .summary    (port_summary)
  );

  always_comb begin
    hi_cause  = (hi_src_q & ~SUM_FIELD) | (W'(port_summary) << SUM_LSB);
    lo_pend   = lo_cause_q & LO_VALID & mask_q[0];
    hi_pend   = hi_cause & HI_VALID & mask_q[1];
    port_pend = port_cause & mask_q[2];
  end

  irqc_resolver #(
    .W(W), .SUM_LSB(SUM_LSB), .GROUPS(GROUPS), .CODE_W(W), .NONE(NONE_CODE)
  ) u_res (
    .lo_pend   (lo_pend),
    .hi_pend   (hi_pend),
    .port_pend (port_pend),
    .valid     (res_valid),
    .code      (res_code)
  );

  always_comb begin
    case (addr_e)
      RA_LO_CAUSE:   rdata_d = lo_cause_q;
      RA_HI_CAUSE:   rdata_d = hi_cause;
      RA_PORT_CAUSE: rdata_d = port_cause;
      RA_LO_MASK:    rdata_d = mask_q[0];
      RA_HI_MASK:    rdata_d = mask_q[1];
      RA_PORT_MASK:  rdata_d = mask_q[2];
      RA_CTRL:       rdata_d = W'(level_q) << LEVEL_BIT;
      default:       rdata_d = cur_code_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code_q <= NONE_CODE;
      irq_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      cur_code_q <= res_code;
      irq_q      <= res_valid;
      rdata_q    <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign cpu_irq   = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int           W         = 32,
  parameter logic [W-1:0] NONE_CODE = 32'hFFFF_FFFE
) (
  input logic         clk,
  input logic         rst,
  input logic         cpu_irq,
  input logic [W-1:0] cur_code,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] lo_mask,
  input logic [W-1:0] hi_mask,
  input logic [W-1:0] port_cause
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_irq && lo_mask == '0 && port_cause == '0)); // R8

  AST_LINE_AGREES: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (cur_code != NONE_CODE)); // R9

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cur_code != NONE_CODE) |-> (cur_code < W'(3 * W))); // R1

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == 3'd2) |=> ((port_cause & $past(port_cause)) == $past(port_cause))); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lo_mask == '0 && hi_mask == '0) |=> !cpu_irq); // R4
endmodule

bind irq_cascade_ctrl irqc_checker #(.W(W), .NONE_CODE(NONE_CODE)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_irq    (cpu_irq),
  .cur_code   (cur_code_q),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .lo_mask    (mask_q[0]),
  .hi_mask    (mask_q[1]),
  .port_cause (port_cause)
);

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
  localparam logic [31:0] NONE = 32'hFFFF_FFFE;
  localparam logic [31:0] LOV  = 32'h3DFF_FFFE;
  localparam logic [31:0] HIV  = 32'h0F00_0DB7;

  logic        clk = 1'b0, rst = 1'b1;
  logic [31:0] src_lo = '0, src_hi = '0, port_pin = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst(rst), .src_lo(src_lo), .src_hi(src_hi), .port_pin(port_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  // behavioural reference model
  logic [31:0] m_lo, m_hs, m_pq, m_pp, m_pc, m_lm, m_hm, m_pm, m_code, m_rd;
  logic        m_lvl, m_irq;

  function automatic logic [31:0] m_hicause(logic [31:0] hs, logic [31:0] pc, logic [31:0] pm);
    logic [31:0] r = hs & ~32'h0F00_0000;
    for (int g = 0; g < 4; g++) if (|((pc & pm) >> (8 * g) & 32'hFF)) r[24 + g] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_resolve(logic [31:0] lo, logic [31:0] hc, logic [31:0] pc,
                                             logic [31:0] lm, logic [31:0] hm, logic [31:0] pm);
    for (int i = 0; i < 32; i++) if (lo[i] && LOV[i] && lm[i]) return i;
    for (int i = 0; i < 32; i++) begin
      if (hc[i] && HIV[i] && hm[i]) begin
        if (i >= 24 && i <= 27) begin
          for (int j = 0; j < 32; j++) if (pc[j] && pm[j]) return 64 + j;
          return NONE;
        end
        return 32 + i;
      end
    end
    return NONE;
  endfunction

  always @(posedge clk) begin
    logic [31:0] hc, res, rd, cap, npc;
    if (rst) begin
      m_lo = 0; m_hs = 0; m_pq = 0; m_pp = 0; m_pc = 0; m_lm = 0; m_hm = 0; m_pm = 0;
      m_lvl = 0; m_code = NONE; m_irq = 0; m_rd = 0;
    end else begin
      hc  = m_hicause(m_hs, m_pc, m_pm);
      res = m_resolve(m_lo, hc, m_pc, m_lm, m_hm, m_pm);
      case (reg_addr)
        3'd0: rd = m_lo;   3'd1: rd = hc;     3'd2: rd = m_pc;  3'd3: rd = m_lm;
        3'd4: rd = m_hm;   3'd5: rd = m_pm;   3'd6: rd = {21'd0, m_lvl, 10'd0};
        default: rd = m_code;
      endcase
      cap = m_lvl ? m_pq : (m_pq & ~m_pp);
      npc = m_pc;
      if (reg_we && reg_addr == 3'd2) npc = npc & reg_wdata;
      npc = npc | cap;
      if (reg_we) begin
        if (reg_addr == 3'd3) m_lm = reg_wdata;
        if (reg_addr == 3'd4) m_hm = reg_wdata;
        if (reg_addr == 3'd5) m_pm = reg_wdata;
        if (reg_addr == 3'd6) m_lvl = reg_wdata[10];
      end
      m_code = res; m_irq = (res != NONE); m_rd = rd;
      m_lo = src_lo; m_hs = src_hi; m_pp = m_pq; m_pq = port_pin; m_pc = npc;
    end
    started = 1;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(cpu_irq === m_irq, "R9 line vs model", 32'(cpu_irq), 32'(m_irq));
      check(reg_rdata === m_rd, "R10 read data vs model", reg_rdata, m_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_expect(logic [2:0] a, logic [31:0] exp, string req);
    @(negedge clk); reg_addr = a;
    @(negedge clk);
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'(checks), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 0;
    // R8 reset state
    check(cpu_irq === 1'b0, "R8 line low", 32'(cpu_irq), 0);
    rd_expect(3'd3, 0, "R8 lower mask");
    rd_expect(3'd4, 0, "R8 upper mask");
    rd_expect(3'd5, 0, "R8 port mask");
    rd_expect(3'd2, 0, "R8 port cause");
    rd_expect(3'd6, 0, "R8 control");
    rd_expect(3'd7, NONE, "R8 resolved word");

    // R3 ineligible lower bits
    wr(3'd3, '1);
    src_lo = 32'hC200_0001; idle(4);
    rd_expect(3'd7, NONE, "R3 ineligible bits");
    // R2 lowest in lower bank
    src_lo = 32'hC200_00A1; idle(4);
    rd_expect(3'd7, 5, "R2 lowest lower bit");

    // R4 upper-bank eligibility, unit input on summary bit ignored
    src_lo = 0; wr(3'd4, '1);
    src_hi = 32'h0100_0048; idle(4);
    rd_expect(3'd1, 32'h0000_0048, "R4 summary ignores inputs");
    rd_expect(3'd7, NONE, "R4 ineligible upper bits");
    src_hi = 32'h0100_0448; idle(4);
    rd_expect(3'd7, 42, "R1 upper number mapping");
    // R2 lower bank before upper
    src_lo = 32'h0000_0200; src_hi = 32'h0000_0001; idle(4);
    rd_expect(3'd7, 9, "R2 lower before upper");
    src_lo = 0; src_hi = 0;

    // R7 edge capture, R4 group summary, R5 descent
    wr(3'd5, '1);
    @(negedge clk); port_pin = 32'h0000_1000;
    @(negedge clk); port_pin = 0;
    idle(4);
    rd_expect(3'd2, 32'h0000_1000, "R7 edge latched");
    rd_expect(3'd1, 32'h0200_0000, "R4 group summary bit");
    rd_expect(3'd7, 76, "R5 port descent");
    port_pin = 32'h0010_0000; idle(4);
    rd_expect(3'd7, 76, "R5 lowest port bit");
    wr(3'd2, ~32'h0000_1000); idle(3);
    rd_expect(3'd7, 84, "R6 clear by zero");
    wr(3'd2, '1); idle(2);
    rd_expect(3'd2, 32'h0010_0000, "R6 ones keep");
    wr(3'd2, ~32'h0010_0000); idle(2);
    rd_expect(3'd2, 0, "R7 held pin no recapture in edge mode");
    rd_expect(3'd7, NONE, "R9 nothing pending");

    // R2 upper non-summary bit beats summary
    @(negedge clk); port_pin = 32'h0010_0002;
    @(negedge clk); port_pin = 32'h0010_0000;
    src_hi = 1; idle(4);
    rd_expect(3'd7, 32, "R2 upper bit 0 before summary");
    src_hi = 0; idle(4);
    rd_expect(3'd7, 65, "R5 descent after upper clears");
    wr(3'd2, 0); idle(2);

    // R7 level mode
    wr(3'd6, 32'h0000_0400);
    rd_expect(3'd6, 32'h0000_0400, "R10 control readback");
    port_pin = 32'h0010_0008; idle(4);
    wr(3'd2, ~32'h0000_0008); idle(2);
    rd_expect(3'd2, 32'h0010_0008, "R7 level overrides clear");
    port_pin = 0; idle(3);
    wr(3'd2, 0); idle(2);
    rd_expect(3'd2, 0, "R7 level clears after release");

    // R7 same-cycle edge capture and clear
    wr(3'd6, 0); idle(2);
    @(negedge clk); port_pin = 32'h0000_0020;
    reg_we = 1; reg_addr = 3'd2; reg_wdata = ~32'h0000_0020;
    idle(2); reg_we = 0; port_pin = 0;
    idle(2);
    rd_expect(3'd2, 32'h0000_0020, "R7 capture wins over clear");
    wr(3'd2, 0); idle(4);

    // R11 latency on a main input
    @(negedge clk); src_lo = 32'h0000_0010;
    @(negedge clk); check(cpu_irq === 1'b0, "R11 not after one edge", 32'(cpu_irq), 0);
    @(negedge clk); check(cpu_irq === 1'b1, "R11 after two edges", 32'(cpu_irq), 1);

    // R10 writes to read-only words ignored
    wr(3'd0, 0); wr(3'd7, 0); idle(1);
    rd_expect(3'd0, 32'h0000_0010, "R10 read-only cause");
    rd_expect(3'd7, 4, "R10 read-only resolved word");

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule